// File: doc/BRIEF.md
# Pipelined Source-to-Destination Crossbar Switch

This block carries transfer requests from eight source ports to nine destination ports. Every source presents a destination number and a payload with a valid/ready handshake, and each accepted request is parked in a small queue that belongs only to its source-destination pair. Each destination then picks one waiting request per cycle with a rotating-priority arbiter. It delivers the payload, tagged with the number of the source that sent it.

A request moves through four fixed stages. In the request stage it is presented and accepted into its pair queue. In the arbitration stage the destination compares the heads of its eight pair queues. In the selection stage the winning head is popped and latched. In the transmission stage the payload drives the destination port. A request that meets no contention therefore appears at its destination a fixed number of cycles after acceptance. Because each pair has a private queue, a full pair stalls only the source that is trying to reach it.

Top module: `xbar_pipe_switch`

## Requirements
- R1: Source s places its destination number in `src_dst[4s+3:4s]` and its payload in `src_data[16s+15:16s]`; destination d reports its source in `dst_src[3d+2:3d]` and its payload in `dst_data[16d+15:16d]`. Destination numbers 0 to 8 are valid; for 9 to 15 `src_ready` of that source stays low and nothing is accepted.
- R2: After synchronous reset every `dst_valid` bit is low and every source naming a valid destination sees `src_ready` high.
- R3: A request accepted at clock edge t by an otherwise idle destination appears at edge t+2: `dst_valid` is high for exactly one cycle, with the sending source's number and the unchanged payload.
- R4: Each source-destination pair holds at most two waiting requests. `src_ready` of a source is low exactly when the pair selected by its current destination number already holds two. A source aiming at a pair with room stays ready.
- R5: Each destination grants in round-robin order. The search starts at the source after the last winner and wraps from 7 to 0. After reset, source 0 has the highest priority.
- R6: Requests from one source to one destination are delivered in the order they were accepted, none lost and none duplicated.
- R7: Different destinations deliver in the same cycle. One source wins at several destinations in one cycle when it has heads waiting at each of them.
- R8: A destination delivers at most one request per cycle. It delivers one in every cycle while any of its pair queues has been non-empty for an arbitration cycle, with no idle cycles in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 8 | Request present, one bit per source |
| src_dst | input | 32 | Destination number, 4 bits per source |
| src_data | input | 128 | Payload, 16 bits per source |
| src_ready | output | 8 | Request accepted at this edge if valid |
| dst_valid | output | 9 | Delivery present, one bit per destination |
| dst_src | output | 27 | Sending source number, 3 bits per destination |
| dst_data | output | 144 | Delivered payload, 16 bits per destination |

## Verification
The two functions that meet in one cycle are the enqueue of a new request into a pair queue and the pop of that same queue's head by the destination's grant. The backpressure decision is made while the count is changing under both. The bench provokes this by having all eight sources push twice in a row at one destination, then retargets one source at another destination. It judges the result by the exact `src_ready` pattern, whose value is worked out from the round-robin order. It then requires seventeen back-to-back deliveries with every pair's sequence numbers in order.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int XB_NSRC   = 8;
    localparam int XB_NDST   = 9;
    localparam int XB_DATA_W = 16;
    localparam int XB_QDEPTH = 2;
    localparam int XB_SRC_W  = $clog2(XB_NSRC);
    localparam int XB_DST_W  = $clog2(XB_NDST);

    typedef logic [XB_DATA_W-1:0] xb_data_t;
    typedef logic [XB_SRC_W-1:0]  xb_src_t;
    typedef logic [XB_DST_W-1:0]  xb_dst_t;

    // One beat moving through the selection and transmission registers
    typedef struct packed {
        logic     vld;
        xb_src_t  src;
        xb_data_t data;
    } xb_beat_t;

    // Wrap-around increment of a small pointer
    function automatic int wrap_inc(input int p, input int limit);
        return (p == limit - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/xbar_pair_fifo.sv
module xbar_pair_fifo
    import xbar_pkg::*;
#(
    parameter int DEPTH = XB_QDEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  xb_data_t push_data,
    input  logic     pop,
    output logic     head_vld,
    output xb_data_t head_data,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    xb_data_t        slot_q [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_data;
                wr_q         <= AW'(wrap_inc(int'(wr_q), DEPTH));
            end
            if (pop) begin
                rd_q <= AW'(wrap_inc(int'(rd_q), DEPTH));
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head_vld  = (cnt_q != '0);
    assign head_data = slot_q[rd_q];
    assign full      = (cnt_q == CW'(DEPTH));

    // R4: the source handshake never writes into a full pair queue
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH)));

    // R6: the arbiter never pops an empty pair queue
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
    import xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [XB_NSRC-1:0] req,
    output logic               gnt_vld,
    output xb_src_t            gnt_idx
);
    xb_src_t last_q;
    int      cand;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        cand    = 0;
        for (int k = 1; k <= XB_NSRC; k++) begin
            cand = (int'(last_q) + k) % XB_NSRC;
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = XB_SRC_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= XB_SRC_W'(XB_NSRC - 1);
        else if (gnt_vld) last_q <= gnt_idx;
    end

    // R5: a grant only goes to a source with a waiting head
    p_grant_has_req_r5: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);

    // R5: with a competitor present, the previous winner does not win again
    p_rotate_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(gnt_vld) && gnt_vld && ($countones(req) > 1))
        |-> (gnt_idx != $past(gnt_idx)));

endmodule

// File: rtl/xbar_dst_port.sv
module xbar_dst_port
    import xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [XB_NSRC-1:0] head_vld,
    input  xb_data_t           head_data [XB_NSRC],
    output logic [XB_NSRC-1:0] pop,
    output xb_beat_t           out_beat
);
    logic     gnt_vld;
    xb_src_t  gnt_idx;
    xb_beat_t sel_q, tx_q;

    // Arbitration stage
    xbar_rr_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (head_vld),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        pop = '0;
        if (gnt_vld) pop[gnt_idx] = 1'b1;
    end

    // Selection stage latches the popped head, transmission stage drives the port
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            tx_q  <= '0;
        end else begin
            sel_q.vld  <= gnt_vld;
            sel_q.src  <= gnt_idx;
            sel_q.data <= head_data[gnt_idx];
            tx_q       <= sel_q;
        end
    end

    assign out_beat = tx_q;

    // R8: at most one pair queue drains into this destination per cycle
    p_one_pop_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));

    // R8: waiting heads are never left unserved for a cycle
    p_no_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        (|head_vld) |-> (pop != '0));

endmodule

// File: rtl/xbar_pipe_switch.sv
module xbar_pipe_switch
    import xbar_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [XB_NSRC-1:0]            src_valid,
    input  logic [XB_NSRC*XB_DST_W-1:0]   src_dst,
    input  logic [XB_NSRC*XB_DATA_W-1:0]  src_data,
    output logic [XB_NSRC-1:0]            src_ready,
    output logic [XB_NDST-1:0]            dst_valid,
    output logic [XB_NDST*XB_SRC_W-1:0]   dst_src,
    output logic [XB_NDST*XB_DATA_W-1:0]  dst_data
);
    logic [XB_NDST-1:0] full_m [XB_NSRC];
    logic [XB_NSRC-1:0] hv_m   [XB_NDST];
    logic [XB_NSRC-1:0] pop_m  [XB_NDST];
    xb_data_t           hd_m   [XB_NDST][XB_NSRC];
    xb_beat_t           beat_m [XB_NDST];

    // Request stage: per-source ready from the selected pair's fill state
    always_comb begin
        for (int s = 0; s < XB_NSRC; s++) begin
            src_ready[s] = 1'b0;
            for (int d = 0; d < XB_NDST; d++) begin
                if (src_dst[s*XB_DST_W +: XB_DST_W] == XB_DST_W'(d))
                    src_ready[s] = !full_m[s][d];
            end
        end
    end

    for (genvar s = 0; s < XB_NSRC; s++) begin : g_src
        for (genvar d = 0; d < XB_NDST; d++) begin : g_pair
            logic push;
            assign push = src_valid[s] && src_ready[s]
                       && (src_dst[s*XB_DST_W +: XB_DST_W] == XB_DST_W'(d));

            xbar_pair_fifo #(.DEPTH(XB_QDEPTH)) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (push),
                .push_data (src_data[s*XB_DATA_W +: XB_DATA_W]),
                .pop       (pop_m[d][s]),
                .head_vld  (hv_m[d][s]),
                .head_data (hd_m[d][s]),
                .full      (full_m[s][d])
            );
        end
    end

    for (genvar d = 0; d < XB_NDST; d++) begin : g_dst
        xbar_dst_port u_port (
            .clk       (clk),
            .rst       (rst),
            .head_vld  (hv_m[d]),
            .head_data (hd_m[d]),
            .pop       (pop_m[d]),
            .out_beat  (beat_m[d])
        );

        assign dst_valid[d]                         = beat_m[d].vld;
        assign dst_src[d*XB_SRC_W +: XB_SRC_W]      = beat_m[d].src;
        assign dst_data[d*XB_DATA_W +: XB_DATA_W]   = beat_m[d].data;
    end

endmodule

// File: tb/xbar_pipe_switch_tb.sv
module xbar_pipe_switch_tb;
    import xbar_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = XB_NSRC;
    localparam int ND = XB_NDST;
    localparam int DW = XB_DST_W;
    localparam int PW = XB_DATA_W;
    localparam int SW = XB_SRC_W;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NS-1:0]        src_valid = '0;
    logic [NS*DW-1:0]     src_dst = '0;
    logic [NS*PW-1:0]     src_data = '0;
    logic [NS-1:0]        src_ready;
    logic [ND-1:0]        dst_valid;
    logic [ND*SW-1:0]     dst_src;
    logic [ND*PW-1:0]     dst_data;

    int nchk = 0;
    int nerr = 0;
    int tx_seq [NS][ND];
    int rx_seq [NS][ND];
    int tx_total = 0;
    int rx_total = 0;
    bit want [NS];
    int dsel [NS];
    logic [NS-1:0] acc;
    logic [NS-1:0] rdy_seen;

    xbar_pipe_switch u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_dst   (src_dst),
        .src_data  (src_data),
        .src_ready (src_ready),
        .dst_valid (dst_valid),
        .dst_src   (dst_src),
        .dst_data  (dst_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mk_payload(input int s, input int d, input int q);
        return {4'(s), 4'(d), 8'(q)};
    endfunction

    // One request-stage cycle: drive at negedge, note ready, account at posedge
    task automatic step();
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            src_valid[s]          = want[s];
            src_dst[s*DW +: DW]   = DW'(dsel[s]);
            src_data[s*PW +: PW]  = (dsel[s] < ND) ? mk_payload(s, dsel[s], tx_seq[s][dsel[s]]) : '0;
        end
        #1;
        rdy_seen = src_ready;
        acc      = src_valid & src_ready;
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            if (acc[s]) begin
                tx_seq[s][dsel[s]]++;
                tx_total++;
            end
        end
        #1;
        src_valid = '0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < NS; s++) begin
            want[s] = 1'b0;
            dsel[s] = 0;
        end
    endtask

    task automatic idle(input int n);
        clear_all();
        for (int i = 0; i < n; i++) step();
    endtask

    // Scoreboard: every delivery matches its pair's next sequence number (R6, R3 payload)
    always @(negedge clk) begin
        int s;
        if (!rst) begin
            for (int d = 0; d < ND; d++) begin
                if (dst_valid[d]) begin
                    s = int'(dst_src[d*SW +: SW]);
                    chk(dst_data[d*PW +: PW] == mk_payload(s, d, rx_seq[s][d]),
                        "R6 pair order/payload", int'(dst_data[d*PW +: PW]),
                        int'(mk_payload(s, d, rx_seq[s][d])));
                    rx_seq[s][d]++;
                    rx_total++;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int d = 0; d < ND; d++) begin
                tx_seq[s][d] = 0;
                rx_seq[s][d] = 0;
            end
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state
        chk(dst_valid == '0, "R2 dst_valid after reset", int'(dst_valid), 0);
        chk(src_ready == '1, "R2 src_ready after reset", int'(src_ready), 255);

        // R1: out-of-range destination number is never accepted
        want[0] = 1'b1; dsel[0] = 9;
        step();
        chk(rdy_seen[0] == 1'b0, "R1 ready for destination 9", int'(rdy_seen[0]), 0);
        want[0] = 1'b1; dsel[0] = 15;
        step();
        chk(acc == '0, "R1 accept for destination 15", int'(acc), 0);
        idle(4);
        chk(rx_total == 0, "R1 no delivery for bad index", rx_total, 0);

        // R3: single-request latency sweep over every pair
        for (int s = 0; s < NS; s++) begin
            for (int d = 0; d < ND; d++) begin
                clear_all();
                want[s] = 1'b1; dsel[s] = d;
                step();
                chk(acc[s] == 1'b1, "R3 idle pair accepts", int'(acc[s]), 1);
                idle(2);
                @(negedge clk);
                chk(dst_valid == ND'(1 << d), "R3 delivery at edge t+2", int'(dst_valid), 1 << d);
                chk(int'(dst_src[d*SW +: SW]) == s, "R3 source tag", int'(dst_src[d*SW +: SW]), s);
                @(negedge clk);
                chk(dst_valid == '0, "R3 one-cycle pulse", int'(dst_valid), 0);
            end
        end
        idle(3);

        // R5/R8: all sources hit destination 3 at once; last winner there is 7
        for (int s = 0; s < NS; s++) begin want[s] = 1'b1; dsel[s] = 3; end
        step();
        idle(2);
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            chk(dst_valid[3] == 1'b1, "R8 back-to-back delivery", int'(dst_valid[3]), 1);
            chk(int'(dst_src[3*SW +: SW]) == k, "R5 round-robin order", int'(dst_src[3*SW +: SW]), k);
        end
        @(negedge clk);
        chk(dst_valid[3] == 1'b0, "R8 idle after drain", int'(dst_valid[3]), 0);
        idle(3);

        // R5/R6: sources 3 and 5 send two each to destination 8 -> 3,5,3,5
        clear_all();
        want[3] = 1'b1; dsel[3] = 8; want[5] = 1'b1; dsel[5] = 8;
        step();
        step();
        idle(1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(int'(dst_src[8*SW +: SW]) == ((k % 2 == 0) ? 3 : 5), "R5 alternating grant",
                int'(dst_src[8*SW +: SW]), (k % 2 == 0) ? 3 : 5);
        end
        idle(3);

        // R4/R8: two pushes from every source to destination 4, then retarget source 7
        for (int s = 0; s < NS; s++) begin want[s] = 1'b1; dsel[s] = 4; end
        step();
        chk(rdy_seen == '1, "R4 first push ready", int'(rdy_seen), 255);
        step();
        chk(rdy_seen == '1, "R4 second push ready", int'(rdy_seen), 255);
        dsel[7] = 0;
        step();
        chk(rdy_seen == 8'b1000_0001, "R4 ready only where room", int'(rdy_seen), 129);
        clear_all();
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            chk(dst_valid[4] == 1'b1, "R8 no bubble while queued", int'(dst_valid[4]), 1);
        end
        @(negedge clk);
        chk(dst_valid[4] == 1'b0, "R8 stop after 17", int'(dst_valid[4]), 0);
        idle(4);

        // R7: source 6 wins at destinations 5 and 6 in the same cycle
        clear_all();
        want[0] = 1'b1; dsel[0] = 5; want[6] = 1'b1; dsel[6] = 5;
        step();
        clear_all();
        want[6] = 1'b1; dsel[6] = 6;
        step();
        idle(1);
        @(negedge clk);
        chk(dst_valid[5] && int'(dst_src[5*SW +: SW]) == 0, "R7 dest 5 first grant", int'(dst_src[5*SW +: SW]), 0);
        chk(dst_valid[6] == 1'b0, "R7 dest 6 not yet", int'(dst_valid[6]), 0);
        @(negedge clk);
        chk(dst_valid[5] && dst_valid[6], "R7 same-cycle double win", int'(dst_valid[6:5]), 3);
        chk(int'(dst_src[5*SW +: SW]) == 6 && int'(dst_src[6*SW +: SW]) == 6, "R7 both from source 6",
            int'(dst_src[6*SW +: SW]), 6);
        idle(4);

        // R7: eight sources to eight different destinations together
        for (int s = 0; s < NS; s++) begin want[s] = 1'b1; dsel[s] = s + 1; end
        step();
        idle(2);
        @(negedge clk);
        chk(dst_valid == 9'b1_1111_1110, "R7 parallel delivery", int'(dst_valid), 510);
        for (int d = 1; d < ND; d++)
            chk(int'(dst_src[d*SW +: SW]) == d - 1, "R7 parallel source tag", int'(dst_src[d*SW +: SW]), d - 1);
        idle(6);

        // R6: nothing lost or duplicated
        chk(rx_total == tx_total, "R6 delivered count", rx_total, tx_total);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule